// File: doc/BRIEF.md
# External I/O Strobe Generator

The block answers a simplified 32-bit register-access bus and steers two external 8/16-bit I/O ports, A and B, which sit behind discrete latches and bus transceivers. Each port owns two indices: a write index and a read index. A write to the write index fires a one-cycle active-low latch pulse toward the external latches and also records the data in an internal shadow register. Reading the write index back returns the shadow from the block itself. A read of the read index fires a one-cycle active-low output-enable pulse toward the external transceiver. The block acknowledges that cycle but keeps its own data outputs released, so the transceiver can drive the bus.

Each port's strobe function is chosen by a strap input that is latched in the first clock after reset is released. When a port's strap is high, its two pins simply forward the general-purpose values supplied on `gpio_i`. The bus indices of that port are then not claimed.

Accesses are single-cycle requests. Acknowledge, strobes and read data all appear in the data phase, which is the cycle that follows the request.

Top module: `xio_strobe_gen`

## Requirements
- R1: A write with `addr_i`=0xE0 and a valid lane pattern drives `pin_no[0]` (port A latch strobe) low for exactly the one cycle after the request, with `sel_o` and `rdy_o` high in that cycle.
- R2: A write with `addr_i`=0xF0 does the same on `pin_no[2]` (port B latch strobe).
- R3: A byte write (`be_i`=4'b0100) stores `wdata_i[23:16]` into shadow bits [7:0] and keeps shadow bits [15:8]. A word write (`be_i`=4'b1100) stores `wdata_i[31:16]` into the whole 16-bit shadow.
- R4: A read of a write index (0xE0 or 0xF0) is acknowledged, fires no strobe, and raises `rdata_oe_o`. For a word read, `rdata_o[31:16]` holds the shadow. For a byte read, `rdata_o[23:16]` holds shadow[7:0]. All other data bits are zero.
- R5: A read of a read index (0xE1 for A on `pin_no[1]`, 0xF1 for B on `pin_no[3]`) drives that pin low for one cycle, raises `sel_o` and `rdy_o`, and keeps `rdata_oe_o` low.
- R6: A write to a read index is acknowledged, fires no strobe and leaves the shadow unchanged.
- R7: An access whose `be_i` is neither 4'b0100 nor 4'b1100, or whose index is not one of the four, is ignored: no acknowledge, no strobe, no shadow change.
- R8: `strap_ni[0]` (port A) and `strap_ni[1]` (port B) are latched in the first clock after reset release. A low strap enables strobe mode. A high strap makes that port's pins equal the matching `gpio_i` bits and leaves its indices unclaimed, until the next reset.
- R9: During and after reset, `sel_o`, `rdy_o` and `rdata_oe_o` are low, the pins follow `gpio_i`, and both shadows read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Single-cycle access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Register index |
| be_i | input | 4 | Byte lane enables |
| wdata_i | input | 32 | Write data |
| sel_o | output | 1 | Device-select acknowledge (data phase) |
| rdy_o | output | 1 | Target-ready acknowledge (data phase) |
| rdata_o | output | 32 | Read data, valid when rdata_oe_o is high |
| rdata_oe_o | output | 1 | Block drives the data bus when high; released when low |
| strap_ni | input | 2 | Strobe-mode straps, [0] port A, [1] port B, active low |
| gpio_i | input | 4 | Plain GPIO pin values used when a port is not in strobe mode |
| pin_no | output | 4 | Port pins: [0] A latch, [1] A enable, [2] B latch, [3] B enable |

## Verification
The bench mixes random requests with directed sequences that switch between byte and word lanes on the same shadow. A design that wrote the whole shadow on a byte access would lose the upper byte, and the read-back would show it. Reads of read indices are checked for acknowledge with the data bus released. A block that drove its own data there would raise the output enable and collide with the transceiver. Writes to read indices, invalid lane patterns and stray indices are each followed by a shadow read-back, and every access is followed by an idle cycle. This exposes a spurious pulse, a stretched strobe, or a shadow that changed when it should not. A second reset with one strap high checks that the disabled port's pins carry the GPIO values and that its indices go unanswered.

// File: rtl/xio_pkg.sv
package xio_pkg;
  typedef enum logic [1:0] {ACC_NONE, ACC_BYTE, ACC_WORD} acc_e;
endpackage

// File: rtl/xio_strap_latch.sv
module xio_strap_latch #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] strap_ni,
  output logic [N-1:0] mode_o
);
  logic armed_q;
  logic [N-1:0] mode_q;

  // capture once, in the first clock after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      mode_q  <= '0;
    end else if (!armed_q) begin
      armed_q <= 1'b1;
      mode_q  <= ~strap_ni;
    end
  end

  assign mode_o = mode_q;

  assert_mode_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> $stable(mode_q));
endmodule

// File: rtl/xio_port.sv
module xio_port
  import xio_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int SH_W  = 16,
  parameter int BYTE_W = 8,
  parameter logic [IDX_W-1:0] WR_IDX = 8'hE0,
  parameter logic [IDX_W-1:0] RD_IDX = 8'hE1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] addr_i,
  input  acc_e             acc_i,
  input  logic [SH_W-1:0]  wdata_i,
  output logic             wr_stb_o,
  output logic             rd_stb_o,
  output logic             hit_o,
  output logic             drive_o,
  output logic [SH_W-1:0]  rd_val_o
);
  localparam int HI_W = SH_W - BYTE_W;

  logic act, at_wr, at_rd;
  logic wr_hit, rd_hit, back_hit, claim;
  logic wr_stb_q, rd_stb_q, hit_q, drive_q;
  logic [SH_W-1:0] shadow_q, rd_val_q, back_val;

  assign act      = req_i && en_i && (acc_i != ACC_NONE);
  assign at_wr    = addr_i == WR_IDX;
  assign at_rd    = addr_i == RD_IDX;
  assign wr_hit   = act && we_i && at_wr;
  assign rd_hit   = act && !we_i && at_rd;
  assign back_hit = act && !we_i && at_wr;
  assign claim    = act && (at_wr || at_rd);
  assign back_val = (acc_i == ACC_BYTE) ? {{HI_W{1'b0}}, shadow_q[BYTE_W-1:0]} : shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_stb_q <= 1'b0;
      rd_stb_q <= 1'b0;
      hit_q    <= 1'b0;
      drive_q  <= 1'b0;
      rd_val_q <= '0;
      shadow_q <= '0;
    end else begin
      wr_stb_q <= wr_hit;
      rd_stb_q <= rd_hit;
      hit_q    <= claim;
      drive_q  <= back_hit;
      rd_val_q <= back_hit ? back_val : '0;
      if (wr_hit) begin
        if (acc_i == ACC_BYTE) shadow_q[BYTE_W-1:0] <= wdata_i[BYTE_W-1:0];
        else                   shadow_q <= wdata_i;
      end
    end
  end

  assign wr_stb_o = wr_stb_q;
  assign rd_stb_o = rd_stb_q;
  assign hit_o    = hit_q;
  assign drive_o  = drive_q;
  assign rd_val_o = rd_val_q;

  assert_wr_acked_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_q |-> hit_q && !drive_q);
  assert_rd_released_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stb_q |-> hit_q && !drive_q);
  assert_no_rd_on_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i) |=> !rd_stb_q && !drive_q);
  assert_shadow_only_on_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hit |=> $stable(shadow_q));
  assert_bad_lanes_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i == ACC_NONE) |=> !hit_q && !wr_stb_q && !rd_stb_q);
endmodule

// File: rtl/xio_strobe_gen.sv
module xio_strobe_gen
  import xio_pkg::*;
#(
  parameter int BUS_W = 32,
  parameter int IDX_W = 8,
  parameter int BYTE_LANE = 2,
  parameter logic [IDX_W-1:0] A_WR_IDX = 8'hE0,
  parameter logic [IDX_W-1:0] A_RD_IDX = 8'hE1,
  parameter logic [IDX_W-1:0] B_WR_IDX = 8'hF0,
  parameter logic [IDX_W-1:0] B_RD_IDX = 8'hF1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] addr_i,
  input  logic [BUS_W/8-1:0] be_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic             sel_o,
  output logic             rdy_o,
  output logic [BUS_W-1:0] rdata_o,
  output logic             rdata_oe_o,
  input  logic [1:0]       strap_ni,
  input  logic [3:0]       gpio_i,
  output logic [3:0]       pin_no
);
  localparam int NPORT    = 2;
  localparam int BE_W     = BUS_W / 8;
  localparam int LANE_LSB = BYTE_LANE * 8;
  localparam int SH_W     = BUS_W - LANE_LSB;
  localparam logic [BE_W-1:0] BE_BYTE = BE_W'(1) << BYTE_LANE;
  localparam logic [BE_W-1:0] BE_WORD = BE_W'(3) << BYTE_LANE;

  acc_e acc;
  logic [NPORT-1:0] mode, wr_stb, rd_stb, hit, drive;
  logic [SH_W-1:0]  rd_val [NPORT];
  logic [SH_W-1:0]  rd_or;

  always_comb begin
    if (be_i == BE_BYTE)      acc = ACC_BYTE;
    else if (be_i == BE_WORD) acc = ACC_WORD;
    else                      acc = ACC_NONE;
  end

  xio_strap_latch #(.N(NPORT)) u_strap (
    .clk_i(clk_i), .rst_ni(rst_ni), .strap_ni(strap_ni), .mode_o(mode)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    xio_port #(
      .IDX_W(IDX_W), .SH_W(SH_W),
      .WR_IDX(p == 0 ? A_WR_IDX : B_WR_IDX),
      .RD_IDX(p == 0 ? A_RD_IDX : B_RD_IDX)
    ) u_port (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(mode[p]),
      .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .acc_i(acc),
      .wdata_i(wdata_i[LANE_LSB +: SH_W]),
      .wr_stb_o(wr_stb[p]), .rd_stb_o(rd_stb[p]), .hit_o(hit[p]),
      .drive_o(drive[p]), .rd_val_o(rd_val[p])
    );
    // strobe mode: active-low pulse; otherwise plain GPIO
    assign pin_no[2*p]   = mode[p] ? !wr_stb[p] : gpio_i[2*p];
    assign pin_no[2*p+1] = mode[p] ? !rd_stb[p] : gpio_i[2*p+1];
  end

  always_comb begin
    rd_or = '0;
    for (int p = 0; p < NPORT; p++) rd_or = rd_or | rd_val[p];
  end

  assign sel_o      = |hit;
  assign rdy_o      = |hit;
  assign rdata_oe_o = |drive;
  assign rdata_o    = {rd_or, {LANE_LSB{1'b0}}};

  assert_one_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_stb, rd_stb}));
  assert_release_on_enable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rd_stb) |-> sel_o && rdy_o && !rdata_oe_o);
  assert_idle_lanes_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_oe_o |-> rdata_o == '0);
endmodule

// File: tb/xio_strobe_gen_test.sv
module xio_strobe_gen_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [3:0] be = '0;
  logic [31:0] wdata = '0;
  logic sel, rdy, oe;
  logic [31:0] rdata;
  logic [1:0] strap = 2'b00;
  logic [3:0] gpio = 4'b1010;
  logic [3:0] pins;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] sh [2];
  logic [1:0] mode;

  always #10 clk = ~clk;

  xio_strobe_gen uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .be_i(be), .wdata_i(wdata), .sel_o(sel), .rdy_o(rdy), .rdata_o(rdata),
    .rdata_oe_o(oe), .strap_ni(strap), .gpio_i(gpio), .pin_no(pins)
  );

  task automatic check(string tag, logic [38:0] act, logic [38:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] idle_pins();
    return {mode[1] ? 2'b11 : gpio[3:2], mode[0] ? 2'b11 : gpio[1:0]};
  endfunction

  task automatic do_reset(logic [1:0] s);
    @(negedge clk);
    rst_ni = 1'b0; strap = s; req = 1'b0;
    @(negedge clk);
    mode = 2'b00;
    check("R9 reset outputs", {sel, rdy, oe, rdata, pins}, {3'b000, 32'h0, gpio});
    rst_ni = 1'b1;
    @(negedge clk);
    mode = ~s;
    sh[0] = '0; sh[1] = '0;
    @(negedge clk);
  endtask

  // one access: request, data-phase check, idle-phase check
  task automatic access(logic w, logic [7:0] a, logic [3:0] b, logic [31:0] d);
    logic valid, byt, ack, exp_oe;
    logic [3:0] exp_pins;
    logic [31:0] exp_rd;
    string tag;
    valid = (b == 4'b0100) || (b == 4'b1100);
    byt = b == 4'b0100;
    ack = 1'b0; exp_oe = 1'b0; exp_rd = '0;
    exp_pins = idle_pins();
    tag = "R7 ignored access";
    for (int p = 0; p < 2; p++) begin
      logic [7:0] wi, ri;
      wi = p == 0 ? 8'hE0 : 8'hF0;
      ri = p == 0 ? 8'hE1 : 8'hF1;
      if (!mode[p] && (a == wi || a == ri)) tag = "R8 disabled port";
      if (valid && mode[p] && (a == wi || a == ri)) begin
        ack = 1'b1;
        if (w && a == wi) begin
          exp_pins[2*p] = 1'b0;
          tag = p == 0 ? "R1 port A latch" : "R2 port B latch";
        end else if (!w && a == ri) begin
          exp_pins[2*p+1] = 1'b0;
          tag = "R5 enable pulse";
        end else if (!w && a == wi) begin
          exp_oe = 1'b1;
          exp_rd = byt ? {8'h00, sh[p][7:0], 16'h0} : {sh[p], 16'h0};
          tag = "R4 shadow read R3";
        end else tag = "R6 write to read index";
      end
    end
    @(negedge clk);
    req = 1'b1; we = w; addr = a; be = b; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; addr = 8'h00; be = 4'h0; wdata = '0;
    check(tag, {sel, rdy, oe, rdata, pins}, {ack, ack, exp_oe, exp_rd, exp_pins});
    for (int p = 0; p < 2; p++) begin
      if (valid && mode[p] && w && a == (p == 0 ? 8'hE0 : 8'hF0)) begin
        if (byt) sh[p][7:0] = d[23:16];
        else     sh[p] = d[31:16];
      end
    end
    @(negedge clk);
    check({tag, " idle R1"}, {sel, rdy, oe, rdata, pins}, {3'b000, 32'h0, idle_pins()});
  endtask

  initial begin
    logic [7:0] idx [5];
    logic [3:0] bes [3];
    void'($urandom(32'd1234));
    idx[0] = 8'hE0; idx[1] = 8'hE1; idx[2] = 8'hF0; idx[3] = 8'hF1; idx[4] = 8'h00;
    bes[0] = 4'b0100; bes[1] = 4'b1100; bes[2] = 4'b0000;
    mode = 2'b00; sh[0] = '0; sh[1] = '0;

    do_reset(2'b00);
    // R9 shadow cleared
    access(1'b0, 8'hE0, 4'b1100, '0);
    access(1'b0, 8'hF0, 4'b1100, '0);
    // R3 byte/word lane mixing
    access(1'b1, 8'hE0, 4'b1100, 32'h1234_5678);
    access(1'b1, 8'hE0, 4'b0100, 32'h00AB_0000);
    access(1'b0, 8'hE0, 4'b1100, '0);
    access(1'b0, 8'hE0, 4'b0100, '0);
    access(1'b1, 8'hF0, 4'b1100, 32'hBEEF_0000);
    // R6 write to read index, then read back shadow
    access(1'b1, 8'hE1, 4'b1100, 32'hFFFF_0000);
    access(1'b0, 8'hE0, 4'b1100, '0);
    // R7 bad lanes and stray index
    access(1'b1, 8'hF0, 4'b0011, 32'h5555_5555);
    access(1'b1, 8'hF0, 4'b1111, 32'h5555_5555);
    access(1'b1, 8'hE2, 4'b1100, 32'h5555_5555);
    access(1'b0, 8'hF0, 4'b1100, '0);
    // R5 enable pulses
    access(1'b0, 8'hE1, 4'b0100, '0);
    access(1'b0, 8'hF1, 4'b1100, '0);

    for (int i = 0; i < 300; i++) begin
      logic [7:0] a;
      logic [3:0] b;
      a = idx[$urandom_range(0, 4)];
      if (a == 8'h00) a = 8'($urandom);
      b = bes[$urandom_range(0, 2)];
      if (b == 4'b0000) b = 4'($urandom);
      access(1'($urandom), a, b, $urandom);
    end

    // R8 port B strap high: GPIO pass-through, indices unclaimed
    gpio = 4'b0110;
    do_reset(2'b10);
    access(1'b1, 8'hF0, 4'b1100, 32'h1111_0000);
    access(1'b0, 8'hF1, 4'b1100, '0);
    access(1'b1, 8'hE0, 4'b0100, 32'h0077_0000);
    access(1'b0, 8'hE0, 4'b1100, '0);
    gpio = 4'b1001;
    access(1'b0, 8'hF0, 4'b1100, '0);
    // R8 port A strap high
    do_reset(2'b01);
    access(1'b1, 8'hE0, 4'b1100, 32'h2222_0000);
    access(1'b0, 8'hE1, 4'b1100, '0);
    access(1'b1, 8'hF0, 4'b0100, 32'h0033_0000);
    access(1'b0, 8'hF0, 4'b1100, '0);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule